// File: doc/BRIEF.md
# Transfer Byte Counter and Address Tracker

This block follows the progress of a data transfer on a peripheral bus. Software loads a 24-bit remaining-byte count through an 8-bit register port, one byte lane at a time. A pulse on `byte_done` marks each byte that has actually completed on the bus, not one that was only fetched or buffered. Each pulse lowers the count by one. In the same clock it raises a 32-bit address tracker by one. Because the tracker moves only in lockstep with confirmed completions, reading it always gives the address of the next byte to complete, whatever prefetching the host side has done.

The address tracker cannot be written from the register port. Neighbouring DMA logic seeds it through `start_addr` and `start_load`. Two sticky status flags, done and wrap, are cleared by writing 1 to them. Each flag reaches the registered `irq` output only while its enable bit is set.

Top module: `xfer_byte_tracker`

## Requirements
- R1: After synchronous reset the count, the address tracker, both flags and both enables are zero, `reg_rdata` is 0 and `irq` is low.
- R2: Offsets 0, 1 and 2 hold count bits 7:0, 15:8 and 23:16. Each is written alone by a write to its offset. `reg_rdata` shows the register selected by `reg_addr` one cycle after the address is presented.
- R3: A `byte_done` pulse with a nonzero count, and with no software write to the count in that cycle, lowers the count by exactly one. This includes borrows across byte lanes.
- R4: Offsets 3 to 6 read the 32-bit address tracker, least significant byte first, and writes to them are ignored. `start_load` copies `start_addr` into it, with priority over a completion in the same cycle. Otherwise it rises by one, wrapping at 2^32, exactly in the cycles where the count falls.
- R5: The done flag (offset 8, bit 0) is set when a completion takes the count from 1 to 0, and it stays set until cleared.
- R6: The wrap flag (offset 8, bit 1) is set when a `byte_done` pulse arrives while the count is zero. That pulse leaves the count and the address unchanged.
- R7: Writing offset 8 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R8: Offset 9 bits 0 and 1 enable done and wrap. `irq` is high in a cycle exactly when, one cycle earlier, some flag and its enable were both set.
- R9: If a flag is being set and cleared by a write in the same cycle, it ends up set.
- R10: Writing offset 7 with bit 0 set clears the count. It does not change the address, does not set any flag, and offset 7 reads 0.
- R11: When a software write to offsets 0 to 2, or a count clear, coincides with `byte_done`, the software value wins. The pulse is dropped: no address step and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| byte_done | input | 1 | One byte completed on the peripheral bus |
| start_load | input | 1 | Load the address tracker |
| start_addr | input | 32 | Value to load into the address tracker |
| irq | output | 1 | Registered masked interrupt |

## Verification
The hardest situations to reach are same-cycle collisions at the edges of the count. The bench creates them directly from the ports. It brings the count to one, then pulses `byte_done` in the very cycle it writes 1 to the done bit. It also issues a count write or a count clear in the cycle of a completion, both with a zero and with a nonzero count, so that the wrap and lockstep rules are tested at the moment they compete. A behavioural model tracks the count, the address, the flags and the enables as integers, and predicts the read data and `irq` on every clock.

// File: rtl/xbt_pkg.sv
package xbt_pkg;
  localparam int unsigned FLAG_DONE = 0;
  localparam int unsigned FLAG_WRAP = 1;
  localparam int unsigned NFLAG     = 2;
  localparam int unsigned CTRL_CLR  = 0;
endpackage

// File: rtl/xbt_count.sv
module xbt_count #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned DW    = 8,
  localparam int unsigned NB   = CNT_W / DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [NB-1:0]    lane_we,
  input  logic [DW-1:0]    wdata,
  input  logic             byte_done,
  output logic [CNT_W-1:0] cnt,
  output logic             step,
  output logic             zero_hit,
  output logic             overrun
);
  logic sw_touch;
  logic is_zero;

  assign sw_touch = clr | (|lane_we);
  assign is_zero  = (cnt == '0);
  assign step     = byte_done & ~sw_touch & ~is_zero;
  assign zero_hit = step & (cnt == CNT_W'(1));
  assign overrun  = byte_done & ~sw_touch & is_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (|lane_we) begin
      for (int i = 0; i < NB; i++) begin
        if (lane_we[i]) cnt[i*DW +: DW] <= wdata;
      end
    end else if (step) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R6
  cnt_floor_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> (cnt == '0));

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/xbt_addr.sv
module xbt_addr #(
  parameter int unsigned ADR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ADR_W-1:0] load_val,
  input  logic             inc,
  output logic [ADR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (inc)  addr <= addr + ADR_W'(1);
  end

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !inc) |=> $stable(addr));
endmodule

// File: rtl/xbt_flags.sv
module xbt_flags #(
  parameter int unsigned NF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  input  logic [NF-1:0] en,
  output logic [NF-1:0] flags,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | set;
      irq   <= |(flags & en);
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_chk
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set[g] |=> flags[g]);
    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[g] && !set[g]) |=> !flags[g]);
  end

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((flags & en) == '0) |=> !irq);
endmodule

// File: rtl/xfer_byte_tracker.sv
module xfer_byte_tracker #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADR_W  = 32,
  parameter int unsigned DW     = 8,
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              byte_done,
  input  logic              start_load,
  input  logic [ADR_W-1:0]  start_addr,
  output logic              irq
);
  import xbt_pkg::*;

  localparam int unsigned CNT_B    = CNT_W / DW;
  localparam int unsigned ADR_B    = ADR_W / DW;
  localparam int unsigned OFS_ADR0 = CNT_B;
  localparam int unsigned OFS_CTRL = CNT_B + ADR_B;
  localparam int unsigned OFS_STAT = OFS_CTRL + 1;
  localparam int unsigned OFS_IEN  = OFS_CTRL + 2;

  logic [CNT_B-1:0] lane_we;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt_q;
  logic [ADR_W-1:0] addr_q;
  logic             step, zero_hit, overrun;
  logic [NFLAG-1:0] flag_set, flag_clr, flags_q, ien_q;
  logic [DW-1:0]    rd_n;

  for (genvar g = 0; g < CNT_B; g++) begin : g_lane
    assign lane_we[g] = reg_wr && (reg_addr == REG_AW'(g));
  end

  assign cnt_clr = reg_wr && (reg_addr == REG_AW'(OFS_CTRL)) && reg_wdata[CTRL_CLR];
  assign flag_clr = (reg_wr && (reg_addr == REG_AW'(OFS_STAT))) ? reg_wdata[NFLAG-1:0] : '0;

  always_comb begin
    flag_set = '0;
    flag_set[FLAG_DONE] = zero_hit;
    flag_set[FLAG_WRAP] = overrun;
  end

  xbt_count #(.CNT_W(CNT_W), .DW(DW)) i_count (
    .clk(clk), .rst(rst), .clr(cnt_clr), .lane_we(lane_we), .wdata(reg_wdata),
    .byte_done(byte_done), .cnt(cnt_q), .step(step), .zero_hit(zero_hit),
    .overrun(overrun)
  );

  xbt_addr #(.ADR_W(ADR_W)) i_addr (
    .clk(clk), .rst(rst), .load(start_load), .load_val(start_addr),
    .inc(step), .addr(addr_q)
  );

  xbt_flags #(.NF(NFLAG)) i_flags (
    .clk(clk), .rst(rst), .set(flag_set), .clr(flag_clr), .en(ien_q),
    .flags(flags_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) ien_q <= '0;
    else if (reg_wr && (reg_addr == REG_AW'(OFS_IEN))) ien_q <= reg_wdata[NFLAG-1:0];
  end

  always_comb begin
    rd_n = '0;
    for (int i = 0; i < CNT_B; i++)
      if (reg_addr == REG_AW'(i)) rd_n = cnt_q[i*DW +: DW];
    for (int i = 0; i < ADR_B; i++)
      if (reg_addr == REG_AW'(OFS_ADR0 + i)) rd_n = addr_q[i*DW +: DW];
    if (reg_addr == REG_AW'(OFS_STAT)) rd_n = DW'(flags_q);
    if (reg_addr == REG_AW'(OFS_IEN))  rd_n = DW'(ien_q);
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_n;
  end

  // R4
  addr_lockstep_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !start_load) |=> (addr_q == $past(addr_q) + ADR_W'(1)));

  // R11
  sw_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && (cnt_clr || (|lane_we)) && !start_load) |=> $stable(addr_q));

  // R5
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !(cnt_clr || (|lane_we)) && (cnt_q == CNT_W'(1)))
      |=> (flags_q[FLAG_DONE] && (cnt_q == '0)));
endmodule

// File: tb/test_xfer_byte_tracker.sv
module test_xfer_byte_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        byte_done = 1'b0;
  logic        start_load = 1'b0;
  logic [31:0] start_addr = '0;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_byte_tracker i_xfer_byte_tracker (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .byte_done(byte_done),
    .start_load(start_load), .start_addr(start_addr), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R1";

  int          m_cnt = 0;
  logic [31:0] m_addr = '0;
  bit          m_done = 0, m_wrap = 0;
  bit [1:0]    m_en = '0;

  function automatic int model_read(input int a);
    if (a <= 2)             return (m_cnt >> (8*a)) & 8'hFF;
    if (a >= 3 && a <= 6)   return int'((m_addr >> (8*(a-3))) & 32'hFF);
    if (a == 8)             return {m_wrap, m_done};
    if (a == 9)             return m_en;
    return 0;
  endfunction

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit wr, input int a, input int d, input bit bd,
                     input bit sl = 0, input logic [31:0] sa = '0);
    int exp_rd, n_cnt;
    bit exp_irq, sw, stp, ovr, hit;
    logic [31:0] n_addr;
    reg_wr = wr; reg_addr = 4'(a); reg_wdata = 8'(d);
    byte_done = bd; start_load = sl; start_addr = sa;
    exp_rd  = model_read(a);
    exp_irq = |({m_wrap, m_done} & m_en);
    sw  = wr && (a <= 2 || (a == 7 && d[0]));
    stp = bd && !sw && m_cnt != 0;
    ovr = bd && !sw && m_cnt == 0;
    hit = stp && m_cnt == 1;
    n_cnt = m_cnt;
    if (wr && a == 7 && d[0]) n_cnt = 0;
    else if (wr && a <= 2) n_cnt = (m_cnt & ~(8'hFF << (8*a))) | ((d & 8'hFF) << (8*a));
    else if (stp) n_cnt = m_cnt - 1;
    n_addr = sl ? sa : (stp ? m_addr + 32'd1 : m_addr);
    @(posedge clk);
    m_cnt  = n_cnt;
    m_addr = n_addr;
    if (wr && a == 8) begin
      if (d[0]) m_done = 0;
      if (d[1]) m_wrap = 0;
    end
    if (hit) m_done = 1;
    if (ovr) m_wrap = 1;
    if (wr && a == 9) m_en = 2'(d);
    @(negedge clk);
    check($sformatf("rdata@%0d", a), reg_rdata, exp_rd);
    check("irq", irq, exp_irq);
    reg_wr = 0; byte_done = 0; start_load = 0;
  endtask

  task automatic rd(input int a); cyc(0, a, 0, 0); endtask
  task automatic wrr(input int a, input int d); cyc(1, a, d, 0); endtask
  task automatic set_cnt(input int v);
    wrr(0, v & 8'hFF); wrr(1, (v >> 8) & 8'hFF); wrr(2, (v >> 16) & 8'hFF);
  endtask
  task automatic dump(); for (int i = 0; i < 10; i++) rd(i); rd(0); endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    cur_req = "R1"; check("irq after reset", irq, 0); check("rdata after reset", reg_rdata, 0);
    dump();

    cur_req = "R2"; set_cnt(24'h123456); dump();
    set_cnt(24'h010001); rd(0); rd(1); rd(2);

    cur_req = "R4"; cyc(0, 3, 0, 0, 1, 32'hFFFFFFFE);
    wrr(3, 8'hAA); wrr(6, 8'h55); dump();

    cur_req = "R3"; cyc(0, 0, 0, 1); rd(0); cyc(0, 2, 0, 1); rd(1); rd(2); dump();

    cur_req = "R8"; wrr(9, 3); set_cnt(2);
    cur_req = "R5"; cyc(0, 8, 0, 1); cyc(0, 8, 0, 1); rd(8); rd(8); dump();

    cur_req = "R6"; cyc(0, 0, 0, 1); rd(3); rd(8); dump();

    cur_req = "R7"; wrr(8, 1); rd(8); rd(8); wrr(8, 0); rd(8); wrr(8, 2); rd(8); rd(8);

    cur_req = "R8"; wrr(9, 1); cyc(0, 8, 0, 1); rd(8); rd(8); wrr(9, 2); rd(8); rd(8);
    wrr(8, 3); rd(8); rd(8);

    cur_req = "R9"; set_cnt(1); cyc(1, 8, 1, 1); rd(8); rd(0); wrr(8, 1); rd(8);

    cur_req = "R10"; set_cnt(5); wrr(7, 1); rd(0); rd(7); rd(8); rd(3); wrr(7, 0); rd(0);

    cur_req = "R11"; set_cnt(3); cyc(1, 0, 9, 1); rd(0); rd(3); rd(8);
    cyc(1, 7, 1, 1); rd(0); rd(3); rd(8); cyc(1, 7, 1, 1); rd(8); rd(3);

    cur_req = "R4"; set_cnt(4); cyc(0, 3, 0, 1, 1, 32'h00000010); rd(3); rd(0);
    cyc(0, 3, 0, 1); rd(3); rd(0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule